// File: doc/BRIEF.md
# Full-Bridge Cell Gate Controller with Fault Polarity Reversal

This block produces the gate signals for the full-bridge cells of a three-phase converter. Each phase has one upper-arm cell and one lower-arm cell, so the default build drives six cells. Each cell has four switches arranged as two legs, A and B. The controller runs in two steps. It first decides a mode for every cell: positive, bypass or negative. It then turns that mode into a switch pattern, and a programmable dead time keeps the two switches of a leg from conducting together.

In normal operation a per-phase PWM request bit from a carrier comparator sets the upper cell to positive or bypass. The lower cell of the same phase takes the complementary mode. When the raw fault indication has stayed high for a fixed number of clock cycles, the protection state latches and the PWM requests are no longer used. The upper cells are then held positive and the lower cells negative, or the reverse when the polarity-swap input is set. The opposing cell voltages cancel and the DC terminal voltage falls to zero.

The latch is released only by a clear request made while the raw fault is low. Normal modulation then restarts through bypass mode. Each time a cell enters bypass it uses the other bypass variant, so that conduction is shared between the upper and the lower switch pairs.

Top module: `fbc_gate_ctrl`

## Requirements
- R1: While reset is high, every cell mode reads bypass (code 2'b00), every gate output is 0 and fault_active_o is 0.
- R2: Outside protection, one clock edge after the PWM bit of a phase is sampled, the upper cell of that phase is positive (code 2'b01) if the bit is 1 and bypass if it is 0. The lower cell takes the opposite mode. Cell index c = 2*phase + arm, with arm 0 the upper cell, and the mode of cell c is at cell_mode_o[2c+1:2c].
- R3: The 4-bit gate group of cell c is gate_o[4c+3:4c], with bit order {B low, B high, A low, A high}. Once settled, positive drives 4'b1001, negative drives 4'b0110, upper bypass drives 4'b0101 and lower bypass drives 4'b1010.
- R4: Every entry into bypass from another mode uses the opposite variant to the previous one. After reset a cell starts in lower bypass, and its first entry uses upper bypass.
- R5: The high and low switches of a leg are never on together. A switch turns on only after the leg has been fully off for at least max(dead_cyc_i, 1) cycles since the opposite switch was last on.
- R6: fault_active_o rises after fault_raw_i has been sampled high on DELAY_CYC consecutive clock edges. A shorter high pulse leaves it at 0.
- R7: During protection, upper cells are positive (01) and lower cells negative (11) when pol_swap_i is 0. When pol_swap_i is 1 the assignment is reversed.
- R8: During protection, changes on pwm_i have no effect on the cell modes or the gate outputs.
- R9: Once set, fault_active_o stays high until fault_clr_i is sampled high while fault_raw_i is low. A clear request made while the raw fault is high has no effect.
- R10: On the edge after the latch is released, every cell is forced to bypass for one cycle. After that the cells follow pwm_i again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | N_PHASE | Per-phase PWM request from the carrier comparator |
| fault_raw_i | input | 1 | Raw DC fault indication |
| fault_clr_i | input | 1 | Request to release the protection latch |
| pol_swap_i | input | 1 | Reverses the arm polarity assignment during protection |
| dead_cyc_i | input | DT_W | Dead time in clock cycles |
| cell_mode_o | output | 2*2*N_PHASE | Mode code of each cell |
| gate_o | output | 4*2*N_PHASE | Gate signals of each cell |
| fault_active_o | output | 1 | Protection latch state |

## Verification
Some properties are checked on every cycle. The assertions enforce the leg interlock and the turn-on gap, the fault pattern on the edge after protection is active, the alternation of bypass variants on each entry, the stickiness of the latch, the conditions under which it releases, and the forced bypass after release. Other behaviour can only be shown by the bench's scenarios. These cover the exact count of edges before latching, the rejection of a pulse one edge short, PWM changes ignored during protection, the effect of the swap input, and the settled gate patterns across random PWM sequences and dead-time settings.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [1:0] {
        MODE_BYP = 2'b00,
        MODE_POS = 2'b01,
        MODE_NEG = 2'b11
    } cell_mode_e;

    // LSB first: A high, A low, B high, B low
    typedef struct packed {
        logic b_lo;
        logic b_hi;
        logic a_lo;
        logic a_hi;
    } cell_gates_t;

    function automatic cell_gates_t mode_gates(cell_mode_e m, logic byp_low);
        cell_gates_t g;
        g = '0;
        case (m)
            MODE_POS: begin g.a_hi = 1'b1; g.b_lo = 1'b1; end
            MODE_NEG: begin g.a_lo = 1'b1; g.b_hi = 1'b1; end
            default: begin
                if (byp_low) begin g.a_lo = 1'b1; g.b_lo = 1'b1; end
                else         begin g.a_hi = 1'b1; g.b_hi = 1'b1; end
            end
        endcase
        return g;
    endfunction

    function automatic cell_mode_e protect_mode(logic is_lower, logic swap);
        return (is_lower ^ swap) ? MODE_NEG : MODE_POS;
    endfunction

    function automatic cell_mode_e pwm_mode(logic is_lower, logic pwm);
        return (pwm ^ is_lower) ? MODE_POS : MODE_BYP;
    endfunction

endpackage

// File: rtl/fbc_fault_latch.sv
module fbc_fault_latch #(
    parameter int DELAY_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic clr_i,
    output logic active_o,
    output logic resume_o
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             lat;
    logic             res;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lat <= 1'b0;
            res <= 1'b0;
        end else begin
            res <= 1'b0;
            if (lat) begin
                cnt <= '0;
                if (clr_i && !raw_i) begin
                    lat <= 1'b0;
                    res <= 1'b1;
                end
            end else if (raw_i) begin
                if (cnt == LAST) lat <= 1'b1;
                else             cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    assign active_o = lat;
    assign resume_o = res;

    // R9: latch holds without a valid clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (lat && !(clr_i && !raw_i)) |=> lat);
    // R9: release only through a clear with raw fault low
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        $fell(lat) |-> ($past(clr_i) && !$past(raw_i)));
    // R6: latching needs the raw fault
    a_r6_needs_raw: assert property (@(posedge clk) disable iff (rst)
        $rose(lat) |-> $past(raw_i));
    // R10: release produces the resume pulse
    a_r10_resume_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(lat) |-> res);

endmodule

// File: rtl/fbc_cell_mode.sv
module fbc_cell_mode
    import fbc_pkg::*;
#(
    parameter bit IS_LOWER = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_i,
    input  logic       fault_i,
    input  logic       resume_i,
    input  logic       swap_i,
    output cell_mode_e mode_o,
    output logic       byp_low_o
);
    cell_mode_e tgt;
    cell_mode_e mode_q;
    logic       byp_low_q;
    logic       alt_q;

    always_comb begin
        if (fault_i)       tgt = protect_mode(IS_LOWER, swap_i);
        else if (resume_i) tgt = MODE_BYP;
        else               tgt = pwm_mode(IS_LOWER, pwm_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_BYP;
            byp_low_q <= 1'b1;
            alt_q     <= 1'b0;
        end else begin
            mode_q <= tgt;
            if (tgt == MODE_BYP && mode_q != MODE_BYP) begin
                byp_low_q <= alt_q;
                alt_q     <= ~alt_q;
            end
        end
    end

    assign mode_o    = mode_q;
    assign byp_low_o = byp_low_q;

    // R7: protection pattern one edge after the latch is seen
    a_r7_protect: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (mode_q == ((IS_LOWER ^ $past(swap_i)) ? MODE_NEG : MODE_POS)));
    // R4: each bypass entry flips the variant
    a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BYP && $past(mode_q) != MODE_BYP) |-> (byp_low_q != $past(byp_low_q)));
    // R10: resume forces bypass
    a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
        (resume_i && !fault_i) |=> (mode_q == MODE_BYP));

endmodule

// File: rtl/fbc_leg_drv.sv
module fbc_leg_drv #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DT_W-1:0] dt_i,
    input  logic            want_hi_i,
    input  logic            want_lo_i,
    output logic            hi_o,
    output logic            lo_o
);
    localparam logic [DT_W-1:0] CNT_MAX = '1;

    logic            hi_q, lo_q;
    logic [DT_W-1:0] off_cnt;
    logic            both_off, nh, nl;

    assign both_off = !hi_q && !lo_q;

    always_comb begin
        nh = want_hi_i && !lo_q && (hi_q || (both_off && off_cnt >= dt_i));
        nl = want_lo_i && !hi_q && (lo_q || (both_off && off_cnt >= dt_i));
        if (nh && nl) nl = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
            off_cnt <= CNT_MAX;
        end else begin
            hi_q <= nh;
            lo_q <= nl;
            if (!nh && !nl) begin
                if (!both_off)              off_cnt <= DT_W'(1);
                else if (off_cnt != CNT_MAX) off_cnt <= off_cnt + 1'b1;
            end else begin
                off_cnt <= '0;
            end
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R5: interlock within the leg
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hi_q && lo_q));
    // R5: turn-on only from a fully off leg
    a_r5_hi_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_q) |-> !$past(lo_q));
    a_r5_lo_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> !$past(hi_q));

endmodule

// File: rtl/fbc_gate_ctrl.sv
module fbc_gate_ctrl
    import fbc_pkg::*;
#(
    parameter int N_PHASE   = 3,
    parameter int DT_W      = 8,
    parameter int DELAY_CYC = 2000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_PHASE-1:0]       pwm_i,
    input  logic                     fault_raw_i,
    input  logic                     fault_clr_i,
    input  logic                     pol_swap_i,
    input  logic [DT_W-1:0]          dead_cyc_i,
    output logic [2*2*N_PHASE-1:0]   cell_mode_o,
    output logic [4*2*N_PHASE-1:0]   gate_o,
    output logic                     fault_active_o
);
    localparam int N_CELL = 2 * N_PHASE;

    logic fault_act;
    logic resume;

    fbc_fault_latch #(.DELAY_CYC(DELAY_CYC)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (fault_raw_i),
        .clr_i    (fault_clr_i),
        .active_o (fault_act),
        .resume_o (resume)
    );

    assign fault_active_o = fault_act;

    for (genvar p = 0; p < N_PHASE; p++) begin : g_ph
        for (genvar a = 0; a < 2; a++) begin : g_arm
            localparam int C = 2 * p + a;
            cell_mode_e  m;
            logic        blow;
            cell_gates_t want;
            logic        ah, al, bh, bl;

            fbc_cell_mode #(.IS_LOWER(a == 1)) u_mode (
                .clk       (clk),
                .rst       (rst),
                .pwm_i     (pwm_i[p]),
                .fault_i   (fault_act),
                .resume_i  (resume),
                .swap_i    (pol_swap_i),
                .mode_o    (m),
                .byp_low_o (blow)
            );

            assign want = mode_gates(m, blow);

            fbc_leg_drv #(.DT_W(DT_W)) u_leg_a (
                .clk       (clk),
                .rst       (rst),
                .dt_i      (dead_cyc_i),
                .want_hi_i (want.a_hi),
                .want_lo_i (want.a_lo),
                .hi_o      (ah),
                .lo_o      (al)
            );

            fbc_leg_drv #(.DT_W(DT_W)) u_leg_b (
                .clk       (clk),
                .rst       (rst),
                .dt_i      (dead_cyc_i),
                .want_hi_i (want.b_hi),
                .want_lo_i (want.b_lo),
                .hi_o      (bh),
                .lo_o      (bl)
            );

            assign cell_mode_o[2*C +: 2] = m;
            assign gate_o[4*C +: 4]      = {bl, bh, al, ah};
        end
    end

    // R7: an arm pair never shows the same nonzero polarity while protected
    a_r7_opposed: assert property (@(posedge clk) disable iff (rst)
        (fault_act && $past(fault_act)) |-> (cell_mode_o[1:0] != cell_mode_o[3:2]));

    // R1: reset state held (checked on the edge after reset)
    a_r1_reset: assert property (@(posedge clk)
        $past(rst) |-> (fault_act == 1'b0 && cell_mode_o == '0));

    if (N_CELL < 2) begin : g_bad
        initial $error("N_PHASE must be at least 1");
    end

endmodule

// File: tb/fbc_gate_ctrl_tb.sv
`timescale 1ns/1ps
module fbc_gate_ctrl_tb_top;
    localparam int NP    = 3;
    localparam int NC    = 2 * NP;
    localparam int DELAY = 2000;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pwm;
    logic          raw, clr, swap;
    logic [7:0]    dt;
    logic [2*NC-1:0] mode_o;
    logic [4*NC-1:0] gate_o;
    logic          fact;

    always #2.5 clk = ~clk;

    fbc_gate_ctrl #(.N_PHASE(NP), .DT_W(8), .DELAY_CYC(DELAY)) dut_i (
        .clk(clk), .rst(rst), .pwm_i(pwm), .fault_raw_i(raw), .fault_clr_i(clr),
        .pol_swap_i(swap), .dead_cyc_i(dt), .cell_mode_o(mode_o), .gate_o(gate_o),
        .fault_active_o(fact)
    );

    int n_chk = 0;
    int n_err = 0;
    int viol  = 0;

    logic [1:0] exp_mode [NC];
    logic       exp_var  [NC];
    logic       alt      [NC];

    function automatic logic [1:0] norm_mode(int c, logic [NP-1:0] p);
        logic up;
        up = p[c/2];
        if (c % 2 == 0) return up ? 2'b01 : 2'b00;
        return up ? 2'b00 : 2'b01;
    endfunction

    function automatic logic [1:0] flt_mode(int c, logic sw);
        return ((c % 2 == 1) ^ sw) ? 2'b11 : 2'b01;
    endfunction

    function automatic logic [3:0] gates_of(logic [1:0] m, logic v);
        case (m)
            2'b01:   return 4'b1001;
            2'b11:   return 4'b0110;
            default: return v ? 4'b1010 : 4'b0101;
        endcase
    endfunction

    task automatic step(int c, logic [1:0] t);
        if (t == 2'b00 && exp_mode[c] != 2'b00) begin
            exp_var[c] = alt[c];
            alt[c]     = ~alt[c];
        end
        exp_mode[c] = t;
    endtask

    task automatic model_pwm();
        for (int c = 0; c < NC; c++) step(c, norm_mode(c, pwm));
    endtask

    task automatic model_fault();
        for (int c = 0; c < NC; c++) step(c, flt_mode(c, swap));
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic check_all(string req);
        logic [2*NC-1:0] em;
        logic [4*NC-1:0] eg;
        for (int c = 0; c < NC; c++) begin
            em[2*c +: 2] = exp_mode[c];
            eg[4*c +: 4] = gates_of(exp_mode[c], exp_var[c]);
        end
        chk({req, " mode"}, 64'(mode_o), 64'(em));
        chk({req, " gates"}, 64'(gate_o), 64'(eg));
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R5 dead-time monitor
    int   off_run [2*NC];
    int   last_side [2*NC];   // 0 none, 1 high, 2 low
    logic prev_h [2*NC];
    logic prev_l [2*NC];
    always @(negedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2*NC; k++) begin
                off_run[k] = 0; last_side[k] = 0; prev_h[k] = 0; prev_l[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2*NC; k++) begin
                logic h, l;
                int   gap;
                h   = gate_o[4*(k/2) + 2*(k%2)];
                l   = gate_o[4*(k/2) + 2*(k%2) + 1];
                gap = (dt == 0) ? 1 : int'(dt);
                if (h && l) viol++;
                if (h && !prev_h[k] && last_side[k] == 2 && off_run[k] < gap) viol++;
                if (l && !prev_l[k] && last_side[k] == 1 && off_run[k] < gap) viol++;
                if (h)      begin last_side[k] = 1; off_run[k] = 0; end
                else if (l) begin last_side[k] = 2; off_run[k] = 0; end
                else        off_run[k] = off_run[k] + 1;
                prev_h[k] = h;
                prev_l[k] = l;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        rst = 1'b1; pwm = '0; raw = 1'b0; clr = 1'b0; swap = 1'b0; dt = 8'd3;
        for (int c = 0; c < NC; c++) begin
            exp_mode[c] = 2'b00; exp_var[c] = 1'b1; alt[c] = 1'b0;
        end
        wait_cyc(5);
        // R1 reset state
        chk("R1 mode", 64'(mode_o), 64'd0);
        chk("R1 gates", 64'(gate_o), 64'd0);
        chk("R1 fault", 64'(fact), 64'd0);
        rst = 1'b0;
        model_pwm();
        wait_cyc(12);
        check_all("R2 R3 R4 after reset");

        // directed alternation: all upper cells in and out of bypass
        pwm = 3'b111; model_pwm(); wait_cyc(12); check_all("R2 R4 pwm all ones");
        pwm = 3'b000; model_pwm(); wait_cyc(12); check_all("R2 R4 pwm all zeros");
        pwm = 3'b111; model_pwm(); wait_cyc(12); check_all("R3 R4 second entry");
        dt = 8'd0;
        pwm = 3'b010; model_pwm(); wait_cyc(8);  check_all("R3 R5 zero dead time");

        for (int i = 0; i < 120; i++) begin
            if (i % 15 == 0) dt = 8'($urandom % 8);
            pwm = NP'($urandom);
            model_pwm();
            wait_cyc(int'(dt) + 6 + int'($urandom % 12));
            check_all("R2 R3 R4 random");
        end

        // R6 pulse one edge short
        raw = 1'b1;
        repeat (DELAY - 1) @(posedge clk);
        @(negedge clk);
        raw = 1'b0;
        wait_cyc(5);
        chk("R6 short pulse", 64'(fact), 64'd0);
        check_all("R6 short pulse modes");

        // R6 exact delay
        raw = 1'b1;
        repeat (DELAY - 1) @(posedge clk);
        @(negedge clk);
        chk("R6 before delay", 64'(fact), 64'd0);
        wait_cyc(1);
        chk("R6 at delay", 64'(fact), 64'd1);
        model_fault();
        wait_cyc(int'(dt) + 6);
        check_all("R7 protect pattern");

        // R8 pwm ignored
        for (int i = 0; i < 6; i++) begin
            pwm = NP'($urandom);
            wait_cyc(int'(dt) + 4);
            check_all("R8 pwm ignored");
        end

        // R9 clear while raw high
        clr = 1'b1; wait_cyc(3); clr = 1'b0;
        chk("R9 clear with raw high", 64'(fact), 64'd1);
        raw = 1'b0;
        wait_cyc(10);
        chk("R9 latched after raw low", 64'(fact), 64'd1);

        // R7 swapped polarity
        swap = 1'b1; model_fault(); wait_cyc(int'(dt) + 6);
        check_all("R7 swapped pattern");

        // R9 / R10 release
        pwm = 3'b101;
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        chk("R9 released", 64'(fact), 64'd0);
        wait_cyc(1);
        chk("R10 forced bypass", 64'(mode_o), 64'd0);
        for (int c = 0; c < NC; c++) step(c, 2'b00);
        model_pwm();
        swap = 1'b0;
        wait_cyc(int'(dt) + 6);
        check_all("R10 resume pwm");

        for (int i = 0; i < 40; i++) begin
            pwm = NP'($urandom);
            model_pwm();
            wait_cyc(int'(dt) + 6 + int'($urandom % 8));
            check_all("R2 R4 after release");
        end

        chk("R5 dead time monitor", 64'(viol), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule